// File: doc/BRIEF.md
# Programmable Bus Wait-State Timer

This block prices each access on a CPU bus whose address space is cut into sixteen regions, chosen by address bits 27:24. For every request it receives the region number, the access kind (load, store, instruction fetch through the prefetch path, or multi-word burst), the width (8/16-bit or 32-bit) and whether the access is sequential. From these it computes how many bus cycles the access takes. It then holds `ready` low for exactly that many cycles. The cost of the most recently accepted access stays visible on `costCycles`.

Wait counts for three external ROM windows and one battery-backed RAM window come from a 16-bit configuration register. Small lookup functions translate the register fields into wait counts. 32-bit costs are built from the 16-bit figures. A prefetch-enable bit removes the prefetch-path penalty on the ROM windows. The external work RAM region has fixed timing, and every other region is a zero-wait fast region.

Top module: `bus_wait_timer`

## Requirements
- R1: After reset, `ready` is 1, `costCycles` is 0 and the configuration register is 0, so a 16-bit nonsequential load from region 8 costs 6 cycles.
- R2: Regions 0, 1, 3–7 and 15 add no wait cycles, whatever the width or sequential flag.
- R3: Region 2 waits 2 cycles for 8/16-bit accesses and 5 cycles for 32-bit accesses, sequential or not.
- R4: ROM window w (w = 0, 1, 2) takes a 2-bit first-access code from configuration bits [2+3w+1 : 2+3w] (bits 3:2, 6:5, 9:8). Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 nonsequential 16-bit waits. Configuration bits 11, 12, 13 and 15 have no effect.
- R5: Configuration bit 4+3w (bits 4, 7, 10) sets the 16-bit sequential wait of window w. When the bit is set the wait is 1. When it is clear the wait is 2, 4 or 8 for windows 0, 1 and 2.
- R6: For a ROM window, the 32-bit nonsequential wait is the 16-bit nonsequential wait plus 1 plus the 16-bit sequential wait. The 32-bit sequential wait is twice the 16-bit sequential wait plus 1.
- R7: Region 14 takes its wait N from the code in configuration bits 1:0, using the same 4/3/2/8 mapping. 8/16-bit accesses wait N, sequential or not, and 32-bit accesses wait 2N+1.
- R8: A load (kind 0) costs 2 plus the wait, and a store (kind 1) costs 1 plus the wait.
- R9: Regions 8/9, 10/11 and 12/13 form windows 0, 1 and 2. Both regions of a window have identical timing.
- R10: A burst (kind 3) of L words costs (1 + N32) + (L − 1)·(1 + S32) cycles, where N32 and S32 are the 32-bit nonsequential and sequential waits of the region. L = 0 is treated as 1. Width and sequential flag are ignored.
- R11: A fetch (kind 2) costs 1 plus the prefetch-path wait of the selected width, and the sequential flag is ignored. In ROM windows this wait is 0 when configuration bit 14 is set. Otherwise, and in every other region, it equals the sequential wait of that width.
- R12: A request is accepted on a rising edge where `reqValid` and `ready` are both 1. `ready` is then low for exactly the access cost in cycles. Requests presented while `ready` is low are ignored and leave `costCycles` unchanged.
- R13: A configuration write applies to accesses accepted after the edge that stores it. An access already running, or accepted on that same edge, keeps the cost it was accepted with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgData | input | 16 | Configuration value to store |
| reqValid | input | 1 | Access request present |
| reqRegion | input | 4 | Region number (address bits 27:24) |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 burst |
| reqWide | input | 1 | 1 for a 32-bit access, 0 for 8/16-bit |
| reqSeq | input | 1 | 1 for a sequential access |
| reqLen | input | LEN_W | Burst length in words (burst kind only) |
| ready | output | 1 | Low while an accepted access is being timed |
| costCycles | output | LEN_W+5 | Cost of the last accepted access |

## Verification
The cost of a request accepted on a rising edge appears on `costCycles` at once, and the bench reads it at the next falling edge. `ready` goes low in that same cycle. The bench counts the falling edges at which `ready` is still low and expects the count to equal the cost exactly. A configuration value is written one full cycle before the request that depends on it. Two directed cases move that write inside the busy window and onto the accepting edge itself, to show that the cost seen is the one in force at acceptance. Requests held high while `ready` is low are checked for leaving both the count and `costCycles` untouched.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  localparam int WT_W      = 5;   // wide enough for the largest wait (17)
  localparam int NUM_WIN   = 3;   // external ROM windows
  localparam int WIN_SLOTS = 4;   // index space of a 2-bit window number
  localparam int WIN_BASE  = 2;   // first configuration bit of window 0
  localparam int WIN_FIELD = 3;   // configuration bits per window
  localparam int PF_BIT    = 14;  // prefetch enable bit

  localparam logic [3:0] RGN_EXT_RAM  = 4'd2;
  localparam logic [3:0] RGN_BATT_RAM = 4'd14;

  localparam logic [WT_W-1:0] EXT_RAM_W16 = WT_W'(2);
  localparam logic [WT_W-1:0] EXT_RAM_W32 = WT_W'(5);

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_BURST = 2'd3
  } accKind_e;

  typedef struct packed {
    logic load;   // latch a new cost and start counting
    logic step;   // count one busy cycle
  } ctrlStrobe_t;

  // First-access code to wait cycles: 0->4, 1->3, 2->2, 3->8
  function automatic logic [WT_W-1:0] firstWait(input logic [1:0] code);
    case (code)
      2'd0:    return WT_W'(4);
      2'd1:    return WT_W'(3);
      2'd2:    return WT_W'(2);
      default: return WT_W'(8);
    endcase
  endfunction

  // Sequential wait: 1 when the fast bit is set, else 2 << window
  function automatic logic [WT_W-1:0] seqWait(input int win, input logic fast);
    return fast ? WT_W'(1) : WT_W'(2 << win);
  endfunction

  function automatic logic isRomRegion(input logic [3:0] rgn);
    return rgn[3] && (rgn[2:1] != 2'b11);
  endfunction

endpackage

// File: rtl/bwt_datapath.sv
module bwt_datapath
  import bwt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CYC_W = LEN_W + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [15:0]      cfgData,
  input  logic [3:0]       reqRegion,
  input  accKind_e         reqKind,
  input  logic             reqWide,
  input  logic             reqSeq,
  input  logic [LEN_W-1:0] reqLen,
  input  ctrlStrobe_t      strobe,
  output logic [CYC_W-1:0] costCycles,
  output logic             lastStep
);

  logic [15:0] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgData;
  end

  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfgReg[15], cfgReg[13:11]};

  // Per-window 16-bit waits decoded from the register fields
  logic [WT_W-1:0] winN16 [WIN_SLOTS];
  logic [WT_W-1:0] winS16 [WIN_SLOTS];

  for (genvar w = 0; w < WIN_SLOTS; w++) begin : g_win
    if (w < NUM_WIN) begin : g_live
      assign winN16[w] = firstWait(cfgReg[WIN_BASE + WIN_FIELD*w +: 2]);
      assign winS16[w] = seqWait(w, cfgReg[WIN_BASE + WIN_FIELD*w + 2]);
    end else begin : g_pad
      assign winN16[w] = '0;
      assign winS16[w] = '0;
    end
  end

  // Region decode into the four wait figures and the prefetch-path waits
  logic            romHit;
  logic [WT_W-1:0] ramN;
  logic [WT_W-1:0] n16, s16, n32, s32, pf16, pf32;

  always_comb begin
    romHit = isRomRegion(reqRegion);
    ramN   = firstWait(cfgReg[1:0]);
    n16 = '0;
    s16 = '0;
    n32 = '0;
    s32 = '0;
    if (reqRegion == RGN_EXT_RAM) begin
      n16 = EXT_RAM_W16;
      s16 = EXT_RAM_W16;
      n32 = EXT_RAM_W32;
      s32 = EXT_RAM_W32;
    end else if (romHit) begin
      n16 = winN16[reqRegion[2:1]];
      s16 = winS16[reqRegion[2:1]];
      n32 = n16 + WT_W'(1) + s16;
      s32 = (s16 << 1) + WT_W'(1);
    end else if (reqRegion == RGN_BATT_RAM) begin
      n16 = ramN;
      s16 = ramN;
      n32 = (ramN << 1) + WT_W'(1);
      s32 = n32;
    end
    pf16 = (romHit && cfgReg[PF_BIT]) ? '0 : s16;
    pf32 = (romHit && cfgReg[PF_BIT]) ? '0 : s32;
  end

  // Cost of the access on offer
  logic [WT_W-1:0]  accWait;
  logic [LEN_W-1:0] lenM1;
  logic [CYC_W-1:0] costNext;

  always_comb begin
    accWait = reqWide ? (reqSeq ? s32 : n32) : (reqSeq ? s16 : n16);
    lenM1   = (reqLen == '0) ? '0 : reqLen - LEN_W'(1);
    case (reqKind)
      KIND_LOAD:  costNext = CYC_W'(accWait) + CYC_W'(2);
      KIND_STORE: costNext = CYC_W'(accWait) + CYC_W'(1);
      KIND_FETCH: costNext = CYC_W'(reqWide ? pf32 : pf16) + CYC_W'(1);
      default:    costNext = CYC_W'(n32) + CYC_W'(1)
                           + CYC_W'(lenM1) * (CYC_W'(s32) + CYC_W'(1));
    endcase
  end

  // Cost latch and busy-cycle down-counter
  logic [CYC_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      costCycles <= '0;
      remain     <= '0;
    end else if (strobe.load) begin
      costCycles <= costNext;
      remain     <= costNext;
    end else if (strobe.step) begin
      remain <= remain - CYC_W'(1);
    end
  end

  assign lastStep = (remain == CYC_W'(1));

  // R12
  cost_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(costCycles));

  // R12
  busy_count_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remain != '0));

  // R8
  cost_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (costCycles != '0));

endmodule

// File: rtl/bwt_ctrl.sv
module bwt_ctrl
  import bwt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lastStep,
  output ctrlStrobe_t strobe,
  output logic        ready
);

  logic busy;

  assign ready       = !busy;
  assign strobe.load = reqValid && !busy;
  assign strobe.step = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busy <= 1'b0;
    else if (strobe.load)     busy <= 1'b1;
    else if (busy && lastStep) busy <= 1'b0;
  end

  // R12
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ready) |=> !ready);

  // R12
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && lastStep) |=> ready);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !reqValid) |=> ready);

endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer
  import bwt_pkg::*;
#(
  parameter  int LEN_W = 8,
  localparam int CYC_W = LEN_W + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [15:0]      cfgData,
  input  logic             reqValid,
  input  logic [3:0]       reqRegion,
  input  logic [1:0]       reqKind,
  input  logic             reqWide,
  input  logic             reqSeq,
  input  logic [LEN_W-1:0] reqLen,
  output logic             ready,
  output logic [CYC_W-1:0] costCycles
);

  ctrlStrobe_t strobe;
  logic        lastStep;

  bwt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lastStep (lastStep),
    .strobe   (strobe),
    .ready    (ready)
  );

  bwt_datapath #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgData    (cfgData),
    .reqRegion  (reqRegion),
    .reqKind    (accKind_e'(reqKind)),
    .reqWide    (reqWide),
    .reqSeq     (reqSeq),
    .reqLen     (reqLen),
    .strobe     (strobe),
    .costCycles (costCycles),
    .lastStep   (lastStep)
  );

  // R13
  cfg_midflight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && cfgWe) |=> $stable(costCycles));

endmodule

// File: tb/bus_wait_timer_test.sv
`timescale 1ns/1ps
module bus_wait_timer_test;

  localparam int LEN_W = 8;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FE = 2'd2, K_BU = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqRegion = '0;
  logic [1:0]  reqKind = '0;
  logic        reqWide = 1'b0;
  logic        reqSeq = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic        ready;
  logic [LEN_W+4:0] costCycles;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bus_wait_timer #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .reqValid(reqValid), .reqRegion(reqRegion), .reqKind(reqKind),
    .reqWide(reqWide), .reqSeq(reqSeq), .reqLen(reqLen),
    .ready(ready), .costCycles(costCycles)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] cfg;
    logic [3:0]  rgn;
    logic [1:0]  kind;
    logic        wide;
    logic        seq;
    logic [7:0]  len;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 48;
  localparam vec_t VEC [0:NVEC-1] = '{
    // R2 fast regions
    '{4'd2, 16'h0000, 4'd0,  K_LD, 1'b0, 1'b0, 8'd0, 16'd2},
    '{4'd2, 16'h0000, 4'd3,  K_ST, 1'b1, 1'b0, 8'd0, 16'd1},
    '{4'd2, 16'h0000, 4'd15, K_LD, 1'b1, 1'b1, 8'd0, 16'd2},
    // R3 external work RAM
    '{4'd3, 16'h0000, 4'd2,  K_LD, 1'b0, 1'b0, 8'd0, 16'd4},
    '{4'd3, 16'h0000, 4'd2,  K_LD, 1'b1, 1'b1, 8'd0, 16'd7},
    '{4'd3, 16'h0000, 4'd2,  K_ST, 1'b1, 1'b0, 8'd0, 16'd6},
    // R4 first-access codes, R9 paired region
    '{4'd4, 16'h0004, 4'd8,  K_LD, 1'b0, 1'b0, 8'd0, 16'd5},
    '{4'd9, 16'h0008, 4'd9,  K_LD, 1'b0, 1'b0, 8'd0, 16'd4},
    '{4'd4, 16'h000C, 4'd8,  K_ST, 1'b0, 1'b0, 8'd0, 16'd9},
    '{4'd4, 16'h0020, 4'd10, K_LD, 1'b0, 1'b0, 8'd0, 16'd5},
    '{4'd4, 16'h0300, 4'd12, K_LD, 1'b0, 1'b0, 8'd0, 16'd10},
    '{4'd4, 16'hB800, 4'd8,  K_LD, 1'b0, 1'b0, 8'd0, 16'd6},
    // R5 sequential bits, R9 paired regions
    '{4'd5, 16'h0000, 4'd8,  K_LD, 1'b0, 1'b1, 8'd0, 16'd4},
    '{4'd5, 16'h0010, 4'd8,  K_LD, 1'b0, 1'b1, 8'd0, 16'd3},
    '{4'd5, 16'h0000, 4'd10, K_LD, 1'b0, 1'b1, 8'd0, 16'd6},
    '{4'd9, 16'h0080, 4'd11, K_LD, 1'b0, 1'b1, 8'd0, 16'd3},
    '{4'd5, 16'h0000, 4'd12, K_LD, 1'b0, 1'b1, 8'd0, 16'd10},
    '{4'd9, 16'h0400, 4'd13, K_LD, 1'b0, 1'b1, 8'd0, 16'd3},
    // R6 32-bit ROM costs
    '{4'd6, 16'h0000, 4'd8,  K_LD, 1'b1, 1'b0, 8'd0, 16'd9},
    '{4'd6, 16'h0000, 4'd8,  K_LD, 1'b1, 1'b1, 8'd0, 16'd7},
    '{4'd6, 16'h0300, 4'd12, K_LD, 1'b1, 1'b0, 8'd0, 16'd19},
    '{4'd6, 16'h0300, 4'd13, K_LD, 1'b1, 1'b1, 8'd0, 16'd19},
    '{4'd6, 16'h0410, 4'd12, K_LD, 1'b1, 1'b0, 8'd0, 16'd8},
    '{4'd6, 16'h0410, 4'd12, K_LD, 1'b1, 1'b1, 8'd0, 16'd5},
    // R7 battery RAM window, R8 store base
    '{4'd7, 16'h0000, 4'd14, K_LD, 1'b0, 1'b0, 8'd0, 16'd6},
    '{4'd7, 16'h0000, 4'd14, K_LD, 1'b0, 1'b1, 8'd0, 16'd6},
    '{4'd7, 16'h0000, 4'd14, K_LD, 1'b1, 1'b0, 8'd0, 16'd11},
    '{4'd7, 16'h0001, 4'd14, K_LD, 1'b0, 1'b1, 8'd0, 16'd5},
    '{4'd8, 16'h0001, 4'd14, K_ST, 1'b1, 1'b0, 8'd0, 16'd8},
    '{4'd7, 16'h0003, 4'd14, K_LD, 1'b1, 1'b1, 8'd0, 16'd19},
    '{4'd8, 16'h0003, 4'd14, K_ST, 1'b0, 1'b0, 8'd0, 16'd9},
    // R11 fetch through the prefetch path
    '{4'd11, 16'h0000, 4'd8,  K_FE, 1'b0, 1'b0, 8'd0, 16'd3},
    '{4'd11, 16'h0000, 4'd8,  K_FE, 1'b1, 1'b0, 8'd0, 16'd6},
    '{4'd11, 16'h4000, 4'd8,  K_FE, 1'b1, 1'b0, 8'd0, 16'd1},
    '{4'd11, 16'h4000, 4'd12, K_FE, 1'b0, 1'b0, 8'd0, 16'd1},
    '{4'd11, 16'h4000, 4'd2,  K_FE, 1'b1, 1'b0, 8'd0, 16'd6},
    '{4'd11, 16'h4000, 4'd14, K_FE, 1'b0, 1'b0, 8'd0, 16'd5},
    '{4'd11, 16'h4000, 4'd0,  K_FE, 1'b0, 1'b0, 8'd0, 16'd1},
    '{4'd11, 16'h4300, 4'd13, K_FE, 1'b1, 1'b1, 8'd0, 16'd1},
    '{4'd11, 16'h0300, 4'd13, K_FE, 1'b1, 1'b1, 8'd0, 16'd18},
    // R10 bursts
    '{4'd10, 16'h0000, 4'd8,  K_BU, 1'b0, 1'b0, 8'd4, 16'd26},
    '{4'd10, 16'h0000, 4'd2,  K_BU, 1'b0, 1'b0, 8'd3, 16'd18},
    '{4'd10, 16'h0000, 4'd0,  K_BU, 1'b0, 1'b0, 8'd5, 16'd5},
    '{4'd10, 16'h0000, 4'd8,  K_BU, 1'b0, 1'b0, 8'd0, 16'd8},
    '{4'd10, 16'h0000, 4'd8,  K_BU, 1'b0, 1'b0, 8'd1, 16'd8},
    '{4'd10, 16'h0410, 4'd12, K_BU, 1'b0, 1'b0, 8'd2, 16'd11},
    '{4'd10, 16'h0003, 4'd14, K_BU, 1'b0, 1'b0, 8'd2, 16'd36},
    '{4'd10, 16'h0000, 4'd12, K_BU, 1'b1, 1'b1, 8'd3, 16'd50}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Leaves the bench at the first falling edge after the accepting edge
  task automatic startReq(input logic [3:0] rgn, input logic [1:0] kind,
                          input logic wide, input logic seq, input logic [7:0] len);
    @(negedge clk);
    reqValid = 1'b1;
    reqRegion = rgn;
    reqKind = kind;
    reqWide = wide;
    reqSeq = seq;
    reqLen = len;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic measure(output int lows);
    lows = 0;
    while (!ready && lows < 10000) begin
      lows++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and default configuration
    chk("R1 ready after reset", int'(ready), 1);
    chk("R1 cost after reset", int'(costCycles), 0);
    startReq(4'd8, K_LD, 1'b0, 1'b0, 8'd0);
    chk("R1 default region 8 cost", int'(costCycles), 6);
    measure(lows);
    chk("R1 default region 8 busy cycles", lows, 6);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      writeCfg(v.cfg);
      startReq(v.rgn, v.kind, v.wide, v.seq, v.len);
      chk($sformatf("R%0d vec%0d cost", v.req, i), int'(costCycles), int'(v.exp));
      measure(lows);
      chk($sformatf("R%0d vec%0d busy cycles (R12)", v.req, i), lows, int'(v.exp));
    end

    // R12 requests during busy are ignored
    writeCfg(16'h0300);
    startReq(4'd12, K_LD, 1'b1, 1'b0, 8'd0);
    reqRegion = 4'd0;
    reqKind = K_ST;
    lows = 0;
    while (!ready && lows < 10000) begin
      reqValid = (lows < 3);
      lows++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk("R12 busy window with ignored requests", lows, 19);
    chk("R12 cost kept after ignored requests", int'(costCycles), 19);
    repeat (2) @(negedge clk);
    chk("R12 no queued request after busy", int'(ready), 1);
    chk("R12 cost unchanged while idle", int'(costCycles), 19);

    // R13 write while an access is running
    writeCfg(16'h0000);
    startReq(4'd8, K_LD, 1'b0, 1'b0, 8'd0);
    lows = 0;
    while (!ready && lows < 10000) begin
      cfgWe = (lows == 0);
      cfgData = 16'h000C;
      lows++;
      @(negedge clk);
    end
    cfgWe = 1'b0;
    chk("R13 running access keeps old cost", lows, 6);
    chk("R13 running access cost value", int'(costCycles), 6);
    startReq(4'd8, K_LD, 1'b0, 1'b0, 8'd0);
    chk("R13 next access uses new config", int'(costCycles), 10);
    measure(lows);
    chk("R13 next access busy cycles", lows, 10);

    // R13 write on the accepting edge
    writeCfg(16'h0000);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgData = 16'h000C;
    reqValid = 1'b1;
    reqRegion = 4'd9;
    reqKind = K_LD;
    reqWide = 1'b0;
    reqSeq = 1'b0;
    @(negedge clk);
    cfgWe = 1'b0;
    reqValid = 1'b0;
    chk("R13 same-edge write keeps old cost", int'(costCycles), 6);
    measure(lows);
    chk("R13 same-edge busy cycles", lows, 6);
    startReq(4'd9, K_LD, 1'b0, 1'b0, 8'd0);
    chk("R13 after same-edge write", int'(costCycles), 10);
    measure(lows);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule